// File: doc/BRIEF.md
# Stacked Register Frame Renamer

This block translates logical integer register numbers into physical register numbers for a register file with two regions. The low 32 logical numbers are global and pass through unchanged. Everything from 32 upward belongs to the active procedure's window. The window always begins at logical 32, but it sits at a moving offset inside a 96-entry physical stacked region, and that offset wraps modulo 96. Read and write ports are translated at the same time, straight from the current frame descriptor. Each port also gets a flag that marks a stacked access falling outside the active window.

The current frame is held as a descriptor with three fields: a linear base offset, a local-register count and an output-register count. A sizing command (alloc) rewrites the two counts. A call pushes the caller's descriptor onto a small saved-descriptor stack. It then advances the base past the caller's locals, so the callee's first stacked register lands on the caller's first output register and no values are copied. The callee starts with zero locals and with the caller's outputs as its outputs. A return pops the saved descriptor back in one cycle. If an alloc would push the total window use past 96 registers, or a call arrives while the descriptor stack is full, the command is rejected and an overflow flag pulses. Spilling to memory is not performed.

A small state machine tracks the nesting of the saved stack. ROOT means no caller is saved. NESTED means at least one caller is saved and there is room for more. FULL means the stack holds DESC_DEPTH entries. Transitions: ROOT to NESTED (or straight to FULL when DESC_DEPTH is 1) on an accepted call. NESTED to FULL on the call that fills the stack. FULL to NESTED, and NESTED to ROOT, on a return that leaves entries behind or empties the stack. Every other command keeps the state.

Top module: `stack_frame_renamer`

## Requirements
- R1: A logical index below 32 maps to the same physical index and never raises its out-of-frame flag.
- R2: A logical index L of 32 or more maps to physical 32 + ((base + L − 32) mod 96), where base is the current frame's linear offset (0 after reset).
- R3: A stacked index L raises its out-of-frame flag exactly when L − 32 ≥ locals + outputs of the current frame. After reset both counts are 0, so every stacked index is flagged.
- R4: An accepted alloc (cmd_op = 2) sets locals to cmd_loc and outputs to cmd_out from the next cycle on, and leaves base unchanged.
- R5: An accepted call (cmd_op = 1) makes base grow by the caller's locals, sets locals to 0 and keeps outputs, so callee logical 32 maps to the physical register of caller logical 32 + locals.
- R6: A return (cmd_op = 3) with at least one saved descriptor restores the caller's base, locals and outputs from the next cycle on.
- R7: An alloc with base + cmd_loc + cmd_out > 96 is rejected: ovf is high for the one cycle after that clock edge and the frame is unchanged. ovf is low in every other cycle.
- R8: A call while DESC_DEPTH descriptors are saved is rejected the same way: ovf pulses for one cycle and the frame is unchanged.
- R9: A return with no saved descriptor has no effect and does not raise ovf.
- R10: A cycle with cmd_valid low, or with cmd_op = 0, changes nothing, whatever cmd_loc and cmd_out hold.
- R11: Every read and write port is translated independently by the R1 to R3 rules, combinationally from the current frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 none, 1 call, 2 alloc, 3 return |
| cmd_loc | input | 7 | Local-register count for alloc |
| cmd_out | input | 7 | Output-register count for alloc |
| rd_lreg | input | NUM_RD×7 | Logical indices of the read ports |
| rd_preg | output | NUM_RD×7 | Physical indices of the read ports |
| rd_oof | output | NUM_RD | Out-of-frame flags of the read ports |
| wr_lreg | input | NUM_WR×7 | Logical indices of the write ports |
| wr_preg | output | NUM_WR×7 | Physical indices of the write ports |
| wr_oof | output | NUM_WR | Out-of-frame flags of the write ports |
| ovf | output | 1 | One-cycle pulse after a rejected alloc or call |

## Verification
The bench uses DESC_DEPTH = 4, two read ports and one write port, with the 96-entry stacked region left at its fixed size. The shallow descriptor stack makes the FULL state and the rejected call reachable within a handful of calls. Random command streams then move in and out of all three states many times. Allocs close to 96 registers reach the exact-fit boundary and the rejection just past it. Out-of-frame indices at a high base reach the modulo wrap of the physical index.

// File: rtl/rsr_pkg.sv
`timescale 1ns/1ps
package rsr_pkg;
    localparam int STATIC_REGS  = 32;
    localparam int STACKED_REGS = 96;
    localparam int LREG_W       = $clog2(STATIC_REGS + STACKED_REGS);
    localparam int CNT_W        = $clog2(STACKED_REGS + 1);

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_CALL  = 2'd1,
        OP_ALLOC = 2'd2,
        OP_RET   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_ROOT   = 2'd0,
        ST_NESTED = 2'd1,
        ST_FULL   = 2'd2
    } ctx_e;

    typedef struct packed {
        logic [CNT_W-1:0] base;
        logic [CNT_W-1:0] loc;
        logic [CNT_W-1:0] out;
    } frame_t;
endpackage

// File: rtl/rsr_map.sv
`timescale 1ns/1ps
module rsr_map
    import rsr_pkg::*;
(
    input  logic [LREG_W-1:0] lreg,
    input  logic [CNT_W-1:0]  base,
    input  logic [CNT_W:0]    span,
    output logic [LREG_W-1:0] preg,
    output logic              oof
);
    localparam int SW = CNT_W + 2;

    logic [CNT_W:0] off;
    logic [SW-1:0]  sum;
    logic [SW-1:0]  wrapped;
    logic           is_static;

    always_comb begin
        is_static = (lreg < LREG_W'(STATIC_REGS));
        off       = (CNT_W+1)'(lreg) - (CNT_W+1)'(STATIC_REGS);
        sum       = SW'(base) + SW'(off);
        wrapped   = (sum >= SW'(STACKED_REGS)) ? (sum - SW'(STACKED_REGS)) : sum;
        if (is_static) begin
            preg = lreg;
            oof  = 1'b0;
        end else begin
            preg = LREG_W'(STATIC_REGS) + LREG_W'(wrapped);
            oof  = (off >= span);
        end
    end
endmodule

// File: rtl/rsr_desc_stack.sv
`timescale 1ns/1ps
module rsr_desc_stack
    import rsr_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       pop,
    input  frame_t                     push_frm,
    output frame_t                     top_frm,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    frame_t          mem [DEPTH];
    logic [IW-1:0]   wr_idx;
    logic [IW-1:0]   rd_idx;

    always_comb begin
        wr_idx  = IW'(count);
        rd_idx  = wr_idx - IW'(1);
        top_frm = mem[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (push) begin
            count <= count + CW'(1);
        end else if (pop) begin
            count <= count - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_idx] <= push_frm;
        end
    end
endmodule

// File: rtl/stack_frame_renamer.sv
`timescale 1ns/1ps
module stack_frame_renamer
    import rsr_pkg::*;
#(
    parameter int NUM_RD     = 2,
    parameter int NUM_WR     = 1,
    parameter int DESC_DEPTH = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cmd_valid,
    input  logic [1:0]                     cmd_op,
    input  logic [CNT_W-1:0]               cmd_loc,
    input  logic [CNT_W-1:0]               cmd_out,
    input  logic [NUM_RD-1:0][LREG_W-1:0]  rd_lreg,
    output logic [NUM_RD-1:0][LREG_W-1:0]  rd_preg,
    output logic [NUM_RD-1:0]              rd_oof,
    input  logic [NUM_WR-1:0][LREG_W-1:0]  wr_lreg,
    output logic [NUM_WR-1:0][LREG_W-1:0]  wr_preg,
    output logic [NUM_WR-1:0]              wr_oof,
    output logic                           ovf
);
    localparam int CW    = $clog2(DESC_DEPTH + 1);
    localparam int TOT_W = CNT_W + 3;

    ctx_e          ctx_q, ctx_d;
    frame_t        frm_q, frm_d;
    frame_t        saved_frm;
    logic          push, pop, ovf_d;
    logic [CW-1:0] depth;
    logic [CNT_W:0] span;
    logic [TOT_W-1:0] alloc_total;
    op_e           op;

    assign span = (CNT_W+1)'(frm_q.loc) + (CNT_W+1)'(frm_q.out);
    assign op   = op_e'(cmd_op);

    rsr_desc_stack #(.DEPTH(DESC_DEPTH)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (pop),
        .push_frm (frm_q),
        .top_frm  (saved_frm),
        .count    (depth)
    );

    // Decision and next-state logic
    always_comb begin
        ctx_d       = ctx_q;
        frm_d       = frm_q;
        push        = 1'b0;
        pop         = 1'b0;
        ovf_d       = 1'b0;
        alloc_total = TOT_W'(frm_q.base) + TOT_W'(cmd_loc) + TOT_W'(cmd_out);
        if (cmd_valid) begin
            unique case (op)
                OP_NONE: begin
                end
                OP_CALL: begin
                    if (ctx_q == ST_FULL) begin
                        ovf_d = 1'b1;
                    end else begin
                        push       = 1'b1;
                        frm_d.base = frm_q.base + frm_q.loc;
                        frm_d.loc  = '0;
                        frm_d.out  = frm_q.out;
                        ctx_d      = (depth == CW'(DESC_DEPTH - 1)) ? ST_FULL : ST_NESTED;
                    end
                end
                OP_ALLOC: begin
                    if (alloc_total > TOT_W'(STACKED_REGS)) begin
                        ovf_d = 1'b1;
                    end else begin
                        frm_d.loc = cmd_loc;
                        frm_d.out = cmd_out;
                    end
                end
                OP_RET: begin
                    if (ctx_q != ST_ROOT) begin
                        pop   = 1'b1;
                        frm_d = saved_frm;
                        ctx_d = (depth == CW'(1)) ? ST_ROOT : ST_NESTED;
                    end
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= ST_ROOT;
            frm_q <= '0;
            ovf   <= 1'b0;
        end else begin
            ctx_q <= ctx_d;
            frm_q <= frm_d;
            ovf   <= ovf_d;
        end
    end

    // Port translation outputs
    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        rsr_map u_map (
            .lreg (rd_lreg[p]),
            .base (frm_q.base),
            .span (span),
            .preg (rd_preg[p]),
            .oof  (rd_oof[p])
        );
    end

    for (genvar p = 0; p < NUM_WR; p++) begin : g_wr
        rsr_map u_map (
            .lreg (wr_lreg[p]),
            .base (frm_q.base),
            .span (span),
            .preg (wr_preg[p]),
            .oof  (wr_oof[p])
        );
    end
endmodule

// File: rtl/rsr_chk.sv
`timescale 1ns/1ps
module rsr_chk
    import rsr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic [CNT_W-1:0]  cmd_loc,
    input logic [CNT_W-1:0]  cmd_out,
    input logic [LREG_W-1:0] lreg0,
    input logic [LREG_W-1:0] preg0,
    input logic              oof0,
    input logic              ovf,
    input ctx_e              ctx,
    input logic [CNT_W-1:0]  base,
    input logic [CNT_W-1:0]  loc,
    input logic [CNT_W-1:0]  out
);
    AST_STATIC_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(lreg0) < STATIC_REGS) |-> (preg0 == lreg0 && !oof0)); // R1

    AST_OOF_BEYOND: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(lreg0) >= STATIC_REGS + int'(loc) + int'(out)) |-> oof0); // R3

    AST_CALL_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd1 && ctx != ST_FULL) |=>
        (int'(base) == int'($past(base)) + int'($past(loc)) && loc == '0 && out == $past(out))); // R5

    AST_ALLOC_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd2 && (int'(base) + int'(cmd_loc) + int'(cmd_out) > STACKED_REGS)) |=>
        (ovf && $stable(base) && $stable(loc) && $stable(out))); // R7

    AST_FULL_CALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd1 && ctx == ST_FULL) |=>
        (ovf && $stable(base) && $stable(loc) && $stable(out))); // R8

    AST_RET_ROOT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd3 && ctx == ST_ROOT) |=>
        (!ovf && $stable(base) && $stable(loc) && $stable(out))); // R9

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid || cmd_op == 2'd0) |=>
        (!ovf && $stable(base) && $stable(loc) && $stable(out))); // R10
endmodule

bind stack_frame_renamer rsr_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_loc   (cmd_loc),
    .cmd_out   (cmd_out),
    .lreg0     (rd_lreg[0]),
    .preg0     (rd_preg[0]),
    .oof0      (rd_oof[0]),
    .ovf       (ovf),
    .ctx       (ctx_q),
    .base      (frm_q.base),
    .loc       (frm_q.loc),
    .out       (frm_q.out)
);

// File: tb/stack_frame_renamer_tb_top.sv
`timescale 1ns/1ps
module stack_frame_renamer_tb_top;
    localparam int NRD = 2;
    localparam int NWR = 1;
    localparam int DD  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic [1:0]       cmd_op = 2'd0;
    logic [6:0]       cmd_loc = '0;
    logic [6:0]       cmd_out = '0;
    logic [NRD-1:0][6:0] rd_lreg = '0;
    logic [NRD-1:0][6:0] rd_preg;
    logic [NRD-1:0]      rd_oof;
    logic [NWR-1:0][6:0] wr_lreg = '0;
    logic [NWR-1:0][6:0] wr_preg;
    logic [NWR-1:0]      wr_oof;
    logic             ovf;

    int n_chk = 0;
    int n_fail = 0;

    // reference model
    int m_base = 0, m_loc = 0, m_out = 0, m_dep = 0;
    int s_base [DD];
    int s_loc  [DD];
    int s_out  [DD];

    always #2.5 clk = ~clk;

    stack_frame_renamer #(.NUM_RD(NRD), .NUM_WR(NWR), .DESC_DEPTH(DD)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_loc(cmd_loc), .cmd_out(cmd_out), .rd_lreg(rd_lreg), .rd_preg(rd_preg),
        .rd_oof(rd_oof), .wr_lreg(wr_lreg), .wr_preg(wr_preg), .wr_oof(wr_oof), .ovf(ovf)
    );

    function automatic int exp_preg(int l);
        if (l < 32) return l;
        return 32 + ((m_base + l - 32) % 96);
    endfunction

    function automatic int exp_oof(int l);
        if (l < 32) return 0;
        return ((l - 32) >= (m_loc + m_out)) ? 1 : 0;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive indices on all ports and compare with the model (R11)
    task automatic check_regs(string req, int l0, int l1, int lw);
        rd_lreg[0] = 7'(l0);
        rd_lreg[1] = 7'(l1);
        wr_lreg[0] = 7'(lw);
        #1;
        chk({req, " R11 rd0 preg"}, int'(rd_preg[0]), exp_preg(l0));
        chk({req, " R11 rd0 oof"},  int'(rd_oof[0]),  exp_oof(l0));
        chk({req, " R11 rd1 preg"}, int'(rd_preg[1]), exp_preg(l1));
        chk({req, " R11 rd1 oof"},  int'(rd_oof[1]),  exp_oof(l1));
        chk({req, " R11 wr0 preg"}, int'(wr_preg[0]), exp_preg(lw));
        chk({req, " R11 wr0 oof"},  int'(wr_oof[0]),  exp_oof(lw));
    endtask

    // apply one command; called in the low phase of the clock
    task automatic do_cmd(string req, bit v, int op, int loc, int out);
        int exp_ovf;
        cmd_valid = v;
        cmd_op    = 2'(op);
        cmd_loc   = 7'(loc);
        cmd_out   = 7'(out);
        @(posedge clk);
        exp_ovf = 0;
        if (v) begin
            case (op)
                1: begin
                    if (m_dep == DD) exp_ovf = 1;
                    else begin
                        s_base[m_dep] = m_base; s_loc[m_dep] = m_loc; s_out[m_dep] = m_out;
                        m_dep++;
                        m_base = m_base + m_loc;
                        m_loc  = 0;
                    end
                end
                2: begin
                    if (m_base + loc + out > 96) exp_ovf = 1;
                    else begin m_loc = loc; m_out = out; end
                end
                3: begin
                    if (m_dep > 0) begin
                        m_dep--;
                        m_base = s_base[m_dep]; m_loc = s_loc[m_dep]; m_out = s_out[m_dep];
                    end
                end
                default: ;
            endcase
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        chk({req, " ovf"}, int'(ovf), exp_ovf);
    endtask

    initial begin
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // reset state
        chk("R7 ovf after reset", int'(ovf), 0);
        check_regs("R1 R3 reset", 5, 32, 127);

        // R4 sizing
        do_cmd("R4 alloc 10/5", 1, 2, 10, 5);
        check_regs("R4 R2 R3 frame 15", 32, 46, 47);
        check_regs("R1 static", 0, 31, 45);

        // R10 ignored commands
        do_cmd("R10 op none", 1, 0, 60, 30);
        check_regs("R10 after op none", 46, 47, 40);
        do_cmd("R10 valid low", 0, 2, 1, 1);
        check_regs("R10 after valid low", 46, 47, 33);

        // R5 calls down to a full stack
        do_cmd("R5 call 1", 1, 1, 0, 0);
        check_regs("R5 callee window", 32, 36, 37);
        do_cmd("R4 nested alloc", 1, 2, 3, 4);
        do_cmd("R5 call 2", 1, 1, 0, 0);
        check_regs("R5 callee 2", 32, 35, 36);
        do_cmd("R5 call 3", 1, 1, 0, 0);
        do_cmd("R5 call 4", 1, 1, 0, 0);
        do_cmd("R8 call when full", 1, 1, 0, 0);
        check_regs("R8 frame kept", 32, 35, 36);

        // R6 returns, then R9 extra return
        for (int i = 0; i < DD; i++) begin
            do_cmd("R6 return", 1, 3, 0, 0);
            check_regs("R6 restored", 32, 40, 47);
        end
        do_cmd("R9 return at root", 1, 3, 0, 0);
        check_regs("R9 frame kept", 32, 46, 47);

        // R7 boundary
        do_cmd("R7 exact fit", 1, 2, 96, 0);
        check_regs("R7 exact fit map", 127, 32, 100);
        do_cmd("R7 one over", 1, 2, 90, 7);
        check_regs("R7 frame kept", 127, 32, 100);
        do_cmd("R4 split 50/46", 1, 2, 50, 46);
        do_cmd("R5 call high", 1, 1, 0, 0);
        do_cmd("R4 callee 20/26", 1, 2, 20, 26);
        do_cmd("R5 call top", 1, 1, 0, 0);
        check_regs("R2 wrap", 57, 60, 127);
        do_cmd("R7 callee over", 1, 2, 0, 27);
        do_cmd("R6 back", 1, 3, 0, 0);
        do_cmd("R6 back", 1, 3, 0, 0);
        check_regs("R6 outer restored", 81, 128 - 1, 70);

        // random mix
        for (int i = 0; i < 600; i++) begin
            int r, op, lc, ot;
            r  = int'($urandom_range(0, 9));
            op = (r < 3) ? 1 : (r < 6) ? 3 : (r < 9) ? 2 : 0;
            lc = int'($urandom_range(0, 40));
            ot = int'($urandom_range(0, 40));
            if ($urandom_range(0, 7) == 0) lc = int'($urandom_range(60, 100));
            do_cmd("R4 R5 R6 R7 R8 R9 random", ($urandom_range(0, 9) != 0), op, lc, ot);
            check_regs("R2 R3 random",
                       int'($urandom_range(0, 127)), int'($urandom_range(32, 127)),
                       int'($urandom_range(0, 127)));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #500000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule